// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block turns a handful of asynchronous external pins into sticky interrupt request flags for a small controller. Two vectored inputs have a software-selected trigger edge, a third vectored input fires on every transition, a quasi-interrupt input fires on rising edges only, and a group of eight key-scan lines raises one shared flag when any enabled line falls. Software reads the flags and clears each one with its own clear strobe. Priority, vectoring and wake-up are handled elsewhere.

Only the first vectored input runs through a two-stage synchroniser and a noise filter. A new level is accepted only after it has stayed constant for the selected window: either two instruction cycles (`2*CYC_DIV` clocks) or `LONG_W` clocks, picked by a mode input. Pulses shorter than the window are thrown away. The other inputs pass through a single capture register and are compared with their previous sample.

Flag bit positions in `req` and `req_clr`: bit 0 is the filtered vectored input, bit 1 the second vectored input, bit 2 the both-edge input, bit 3 the rising quasi-interrupt, and bit 4 the key-scan group.

Top module: `ext_irq_front`

## Requirements
- R1: While `rst` is high and in the first cycle after it drops, every bit of `req` is 0.
- R2: Filtered input edge select: with `vec0_rise`=1 an accepted low-to-high change of `vec0_pin` sets `req[0]` and an accepted high-to-low change does not; with `vec0_rise`=0 the roles swap.
- R3: Filter window W is `2*CYC_DIV` clocks when `vec0_long`=0 and `LONG_W` clocks when `vec0_long`=1. A new level held for at least W clocks is accepted, and `req[0]` reads 1 after the (W+2)-th rising clock edge that follows the pin change. A level held for W-1 clocks or fewer is discarded.
- R4: `vec1_pin` sets `req[1]` after the second clock edge following a change of its sampled level to the value given by `vec1_rise` (1 = rising, 0 = falling). A change in the other direction has no effect.
- R5: Every change of the sampled level of `dual_pin`, rising or falling, sets `req[2]` after the second clock edge.
- R6: A low-to-high change of `quasi_pin` sets `req[3]` after the second clock edge; a high-to-low change has no effect.
- R7: `req[4]` is set after the second clock edge when any line `key_pin[i]` with `key_en[i]`=1 falls from 1 to 0. Falls on lines with `key_en[i]`=0 and rises on any line have no effect.
- R8: Every flag stays set until its own `req_clr` bit is high at a clock edge, after which it reads 0; a clear bit affects only its own flag.
- R9: When a set event for a flag and that flag's clear bit occur at the same clock edge, the flag is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| vec0_pin | input | 1 | Filtered vectored interrupt pin |
| vec0_rise | input | 1 | Edge select for vec0_pin: 1 rising, 0 falling |
| vec0_long | input | 1 | Filter window select: 0 short window, 1 long window |
| vec1_pin | input | 1 | Second vectored interrupt pin, edge selectable |
| vec1_rise | input | 1 | Edge select for vec1_pin: 1 rising, 0 falling |
| dual_pin | input | 1 | Vectored interrupt pin triggered on both edges |
| quasi_pin | input | 1 | Quasi-interrupt pin triggered on rising edges |
| key_pin | input | KEYS | Key-scan lines, falling edge triggered |
| key_en | input | KEYS | Per-line participation mask for the key-scan group |
| req_clr | input | 5 | Per-flag clear strobes |
| req | output | 5 | Sticky interrupt request flags |

## Verification
The bench builds the block with its defaults, `CYC_DIV`=4, `LONG_W`=128 and `KEYS`=8, so the short filter window is 8 clocks and the long one 128 clocks. Both windows are short enough that the bench probes each at exactly W and W-1 clock pulse lengths and times the acceptance edge in both modes. With eight key lines the mask can exclude some lines while others fire. Random toggling of the unfiltered pins and clear strobes is compared cycle by cycle against a model driven only by the pin history.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int NUM_REQ = 5;
  localparam int IDX_V0  = 0;
  localparam int IDX_V1  = 1;
  localparam int IDX_DU  = 2;
  localparam int IDX_QU  = 3;
  localparam int IDX_KEY = 4;
  typedef logic [NUM_REQ-1:0] req_vec_t;
endpackage

// File: rtl/pin_capture.sv
// Single capture register per pin plus one history register, giving the
// current and previous sampled level for edge comparison.
module pin_capture #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin,
  output logic [N-1:0] cur,
  output logic [N-1:0] old
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
      old <= '0;
    end else begin
      cur <= pin;
      old <= cur;
    end
  end
endmodule

// File: rtl/glitch_filter.sv
// Two-flop synchroniser followed by a persistence filter. The accepted level
// changes only after the synchronised input has differed from it for a full
// window; accept pulses when that change matches the selected direction.
module glitch_filter #(
  parameter int CYC_DIV = 4,
  parameter int LONG_W  = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic long_sel,
  input  logic rise_sel,
  output logic accept
);
  localparam int SHORT_W = 2 * CYC_DIV;
  localparam int MAX_W   = (SHORT_W > LONG_W) ? SHORT_W : LONG_W;
  localparam int CW      = $clog2(MAX_W + 1);
  localparam logic [CW-1:0] LIM_S = CW'(SHORT_W - 1);
  localparam logic [CW-1:0] LIM_L = CW'(LONG_W - 1);

  logic          s1, s2, lvl;
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          differ, done;

  always_comb begin
    limit  = long_sel ? LIM_L : LIM_S;
    differ = s2 ^ lvl;
    done   = differ && (cnt >= limit);
    accept = done && (s2 == rise_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1  <= 1'b0;
      s2  <= 1'b0;
      lvl <= 1'b0;
      cnt <= '0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      if (!differ) begin
        cnt <= '0;
      end else if (done) begin
        cnt <= '0;
        lvl <= s2;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/flag_bank.sv
// Sticky request flags; a set event outranks a clear in the same cycle.
module flag_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/ext_irq_front.sv
module ext_irq_front #(
  parameter int CYC_DIV = 4,
  parameter int LONG_W  = 128,
  parameter int KEYS    = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vec0_pin,
  input  logic            vec0_rise,
  input  logic            vec0_long,
  input  logic            vec1_pin,
  input  logic            vec1_rise,
  input  logic            dual_pin,
  input  logic            quasi_pin,
  input  logic [KEYS-1:0] key_pin,
  input  logic [KEYS-1:0] key_en,
  input  logic [4:0]      req_clr,
  output logic [4:0]      req
);
  import xirq_pkg::*;

  localparam int RAW_N = 3 + KEYS;

  logic [RAW_N-1:0] raw_now, raw_cur, raw_old;
  logic             v0_accept;
  req_vec_t         set_ev;
  logic             v1_c, v1_o, du_c, du_o, qu_c, qu_o;
  logic [KEYS-1:0]  k_c, k_o;

  assign raw_now = {key_pin, quasi_pin, dual_pin, vec1_pin};

  pin_capture #(.N(RAW_N)) u_cap (
    .clk (clk),
    .rst (rst),
    .pin (raw_now),
    .cur (raw_cur),
    .old (raw_old)
  );

  glitch_filter #(.CYC_DIV(CYC_DIV), .LONG_W(LONG_W)) u_flt (
    .clk      (clk),
    .rst      (rst),
    .pin      (vec0_pin),
    .long_sel (vec0_long),
    .rise_sel (vec0_rise),
    .accept   (v0_accept)
  );

  always_comb begin
    v1_c = raw_cur[0];  v1_o = raw_old[0];
    du_c = raw_cur[1];  du_o = raw_old[1];
    qu_c = raw_cur[2];  qu_o = raw_old[2];
    k_c  = raw_cur[RAW_N-1:3];
    k_o  = raw_old[RAW_N-1:3];
    set_ev          = '0;
    set_ev[IDX_V0]  = v0_accept;
    set_ev[IDX_V1]  = (v1_c != v1_o) && (v1_c == vec1_rise);
    set_ev[IDX_DU]  = du_c ^ du_o;
    set_ev[IDX_QU]  = qu_c & ~qu_o;
    set_ev[IDX_KEY] = |(k_o & ~k_c & key_en);
  end

  flag_bank #(.N(NUM_REQ)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set   (set_ev),
    .clr   (req_clr),
    .flags (req)
  );
endmodule

// File: rtl/ext_irq_front_chk.sv
module ext_irq_front_chk #(
  parameter int KEYS = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            vec1_pin,
  input logic            vec1_rise,
  input logic            quasi_pin,
  input logic [KEYS-1:0] key_pin,
  input logic [KEYS-1:0] key_en,
  input logic [4:0]      req_clr,
  input logic [4:0]      req
);
  // R8: a set flag with no clear stays set
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(req) & ~$past(req_clr)) & ~req) == 5'd0));

  // R6: quasi flag rises only after the pin was sampled high
  p_quasi_src_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(req[3]) |-> $past(quasi_pin, 2));

  // R4: second vectored flag rises only when the sampled level matches the selected edge
  p_vec1_dir_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(req[1]) |-> ($past(vec1_pin, 2) == $past(vec1_rise)));

  // R7: key flag rises only with some line enabled
  p_key_mask_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(req[4]) |-> ($past(key_en) != '0));

  // R7: key flag rises only when some line was sampled low
  p_key_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(req[4]) |-> ($past(key_pin, 2) != {KEYS{1'b1}}));
endmodule

bind ext_irq_front ext_irq_front_chk #(.KEYS(KEYS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .vec1_pin  (vec1_pin),
  .vec1_rise (vec1_rise),
  .quasi_pin (quasi_pin),
  .key_pin   (key_pin),
  .key_en    (key_en),
  .req_clr   (req_clr),
  .req       (req)
);

// File: tb/tb_ext_irq_front.sv
`timescale 1ns/1ps
module tb_ext_irq_front;
  localparam int CYC_DIV = 4;
  localparam int LONG_W  = 128;
  localparam int KEYS    = 8;
  localparam int WS      = 2 * CYC_DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vec0_pin = 1'b0, vec0_rise = 1'b1, vec0_long = 1'b0;
  logic vec1_pin = 1'b0, vec1_rise = 1'b1;
  logic dual_pin = 1'b0, quasi_pin = 1'b0;
  logic [KEYS-1:0] key_pin = '1, key_en = '1;
  logic [4:0] req_clr = '0;
  logic [4:0] req;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ext_irq_front #(.CYC_DIV(CYC_DIV), .LONG_W(LONG_W), .KEYS(KEYS)) dut (
    .clk(clk), .rst(rst), .vec0_pin(vec0_pin), .vec0_rise(vec0_rise),
    .vec0_long(vec0_long), .vec1_pin(vec1_pin), .vec1_rise(vec1_rise),
    .dual_pin(dual_pin), .quasi_pin(quasi_pin), .key_pin(key_pin),
    .key_en(key_en), .req_clr(req_clr), .req(req));

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    req_clr = 5'h1f;
    cyc(1);
    req_clr = 5'h00;
  endtask

  task automatic pulse0(input int len);
    vec0_pin = 1'b1;
    cyc(len);
    vec0_pin = 1'b0;
  endtask

  function automatic logic [4:0] next_flags(
      input logic [4:0] cur, input logic [4:0] clr,
      input logic [10:0] h1, input logic [10:0] h2,
      input logic sel1, input logic [KEYS-1:0] en);
    logic [4:0] s;
    s = '0;
    s[1] = (h1[0] != h2[0]) && (h1[0] == sel1);
    s[2] = h1[1] != h2[1];
    s[3] = h1[2] && !h2[2];
    s[4] = |(h2[10:3] & ~h1[10:3] & en);
    return s | (cur & ~clr);
  endfunction

  initial begin
    #(200000 * 8);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [10:0] h1, h2, d;
    logic [4:0]  exp, clr;
    void'($urandom(32'd20240607));
    cyc(4);
    chk("R1 during reset", req, 5'h00);
    rst = 1'b0;
    cyc(1);
    chk("R1 after reset", req, 5'h00);
    cyc(3);
    chk("R1 idle", req, 5'h00);

    // R3 latency, short window, rising
    vec0_pin = 1'b1;
    cyc(WS + 1);
    chk("R3 short window not yet", req & 5'h01, 5'h00);
    cyc(1);
    chk("R3 short window accepted", req & 5'h01, 5'h01);
    req_clr = 5'h01; cyc(1); req_clr = 5'h00;
    chk("R8 clear vec0", req & 5'h01, 5'h00);
    vec0_pin = 1'b0;
    cyc(WS + 6);
    chk("R2 falling ignored with rise select", req & 5'h01, 5'h00);

    // R3 pulse lengths at the short window boundary
    pulse0(WS - 1); cyc(WS + 10);
    chk("R3 short pulse W-1 discarded", req & 5'h01, 5'h00);
    pulse0(WS); cyc(WS + 10);
    chk("R3 short pulse W accepted", req & 5'h01, 5'h01);
    clear_all();

    // R2 falling select
    vec0_rise = 1'b0;
    vec0_pin = 1'b1; cyc(WS + 10);
    chk("R2 rising ignored with fall select", req & 5'h01, 5'h00);
    vec0_pin = 1'b0; cyc(WS + 10);
    chk("R2 falling accepted with fall select", req & 5'h01, 5'h01);
    clear_all();

    // R3 long window
    vec0_rise = 1'b1; vec0_long = 1'b1;
    cyc(2);
    pulse0(LONG_W - 1); cyc(LONG_W + 10);
    chk("R3 long pulse W-1 discarded", req & 5'h01, 5'h00);
    vec0_pin = 1'b1;
    cyc(LONG_W + 1);
    chk("R3 long window not yet", req & 5'h01, 5'h00);
    cyc(1);
    chk("R3 long window accepted", req & 5'h01, 5'h01);
    vec0_pin = 1'b0; cyc(LONG_W + 10);
    clear_all();
    chk("R8 clear after long", req, 5'h00);

    // R6 and R9 on the quasi input
    quasi_pin = 1'b1; cyc(3); quasi_pin = 1'b0; cyc(3);
    chk("R6 quasi rising sets", req, 5'h08);
    quasi_pin = 1'b1; cyc(1);
    req_clr = 5'h08; cyc(1);
    chk("R9 set wins over clear", req, 5'h08);
    cyc(1);
    req_clr = 5'h00;
    chk("R8 clear quasi", req, 5'h00);
    quasi_pin = 1'b0; cyc(4);
    chk("R6 quasi falling ignored", req, 5'h00);

    // R7 key mask
    key_en = 8'h0f;
    key_pin = 8'hdf; cyc(4);
    chk("R7 masked key fall ignored", req, 5'h00);
    key_pin = 8'hff; cyc(3);
    chk("R7 key rise ignored", req, 5'h00);
    key_pin = 8'hfb; cyc(1);
    chk("R7 key latency not yet", req, 5'h00);
    cyc(1);
    chk("R7 enabled key fall sets", req, 5'h10);
    key_pin = 8'hff; cyc(3);
    clear_all();

    // R4 second vectored input, falling select
    vec1_rise = 1'b0;
    vec1_pin = 1'b1; cyc(4);
    chk("R4 rising ignored with fall select", req, 5'h00);
    vec1_pin = 1'b0; cyc(4);
    chk("R4 falling sets with fall select", req, 5'h02);
    clear_all();

    // R5 both edges
    dual_pin = 1'b1; cyc(4);
    chk("R5 rising sets", req, 5'h04);
    clear_all();
    dual_pin = 1'b0; cyc(4);
    chk("R5 falling sets", req, 5'h04);
    clear_all();
    cyc(2);
    chk("R8 all clear before random", req, 5'h00);

    // Random phase on the unfiltered inputs
    key_en = '1;
    h1 = {key_pin, quasi_pin, dual_pin, vec1_pin};
    h2 = h1;
    exp = 5'h00;
    for (int j = 0; j < 1500; j++) begin
      @(negedge clk);
      if (req[0] !== exp[0]) chk("R2 vec0 idle", req & 5'h01, exp & 5'h01);
      else tests++;
      chk("R4 vec1 random", req & 5'h02, exp & 5'h02);
      chk("R5 dual random", req & 5'h04, exp & 5'h04);
      chk("R6 quasi random", req & 5'h08, exp & 5'h08);
      chk("R7 key random", req & 5'h10, exp & 5'h10);
      d = {KEYS+3{1'b0}};
      for (int b = 0; b < 11; b++) d[b] = (($urandom % 5) == 0) ? ~h1[b] : h1[b];
      clr = '0;
      for (int b = 0; b < 5; b++) clr[b] = (($urandom % 4) == 0);
      if (($urandom % 16) == 0) vec1_rise = ~vec1_rise;
      if (($urandom % 32) == 0) key_en = 8'($urandom);
      {key_pin, quasi_pin, dual_pin, vec1_pin} = d;
      req_clr = clr;
      exp = next_flags(exp, clr, h1, h2, vec1_rise, key_en);
      h2 = h1;
      h1 = d;
    end
    req_clr = 5'h00;

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule